// File: doc/BRIEF.md
# Cascadable LCD Segment Column Driver

This block takes one display line of column bits from a narrow parallel bus and turns each column into a drive-level code. The bus is either four or eight bits wide. A data strobe carries the words in. Each accepted falling strobe edge writes one bus word into the next free columns of an input line register. Columns can fill from the first column upward or from the last column downward.

Several copies can be chained into a wide panel. Each copy takes part only while its active-low chain enable is low. Once its line register is full, it pulls its own chain output low, which hands the bus to the next copy. The direction input also swaps the roles of the two chain pins, so the chain runs the same way as the fill.

A falling edge on the line-transfer strobe copies the captured line into an output latch. The same edge rewinds the fill position and releases the chain output. Every column then presents a 2-bit level code. The code depends on the latched bit, the frame alternation input and an active-low blanking input. Both of those inputs act on the codes at once, without waiting for a transfer.

All strobes are sampled on the system clock `clk`. A strobe edge is seen as a high sample followed by a low sample. A capture or transfer takes effect on the clock edge at which the low level is first sampled.

Top module: `lcdcol_driver`

## Requirements
- R1: After reset, the input line register and the output latch hold all zeros. Both chain outputs are high. With blanking off and alternation high, every column therefore reads code 01.
- R2: With `bus8`=1 and `rev`=0, the k-th accepted strobe (k from 0) writes `din[7]` to column 8k+1, `din[6]` to column 8k+2, and so on down to `din[0]` on column 8k+8.
- R3: With `bus8`=0, each accepted strobe writes four columns from `din[3:0]`, most significant bit first. `din[7:4]` has no effect.
- R4: With `rev`=1, filling starts at column NCOL and moves toward column 1. The k-th strobe writes the most significant used bus bit to column NCOL−w·k, where w is the words' width, and the following bits to the columns below it.
- R5: With `rev`=0, the chain input is `chain_a_i` and the chain output is `chain_b_o`. With `rev`=1, the chain input is `chain_b_i` and the chain output is `chain_a_o`. The chain output not in use stays high, and the chain input not in use is ignored.
- R6: A strobe edge that arrives while the active chain input is high changes nothing.
- R7: After NCOL/w accepted strobes the line is full. The active chain output then goes low, and later strobe edges are ignored until the next transfer.
- R8: Column codes reflect only the latched line. Captured data does not reach the outputs until a falling edge of `ld_in`.
- R9: A falling edge of `ld_in` copies the line register into the latch. It rewinds the fill position so the next strobe writes the first column again, and it returns the chain output high.
- R10: With `blank_n` high, each column's code is 00 for alternation 1 with bit 1, 01 for alternation 1 with bit 0, 10 for alternation 0 with bit 0, and 11 for alternation 0 with bit 1. Column c occupies `col_lvl[2c-1:2c-2]`.
- R11: While `blank_n` is low, every column reads code 11, whatever the data or the alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst | input | 1 | Synchronous active-high reset |
| cp_in | input | 1 | Data strobe; the falling edge captures one bus word |
| ld_in | input | 1 | Line-transfer strobe; the falling edge latches the line |
| rev | input | 1 | Fill direction: 0 fills from column 1, 1 fills from column NCOL |
| bus8 | input | 1 | Bus width: 1 uses all 8 bits, 0 uses `din[3:0]` |
| din | input | BUSW | Parallel column data |
| alt_in | input | 1 | Frame alternation |
| blank_n | input | 1 | Active-low blanking; low forces code 11 on every column |
| chain_a_i | input | 1 | Chain enable input when `rev`=0 (active low) |
| chain_b_i | input | 1 | Chain enable input when `rev`=1 (active low) |
| chain_a_o | output | 1 | Chain enable output when `rev`=1 (active low) |
| chain_b_o | output | 1 | Chain enable output when `rev`=0 (active low) |
| col_lvl | output | 2*NCOL | Per-column level code; column 1 in the lowest two bits |

## Verification
The assertions assume that `rev` and `bus8` change only between lines, right after a transfer. They also assume that NCOL is a whole multiple of the bus width, so a line always ends exactly on a word boundary. The bench keeps to both assumptions. It changes the configuration only right after a transfer, and it always uses the default 160 columns. Each strobe level is held for at least one clock, so every edge is seen once.

// File: rtl/lcdcol_pkg.sv
package lcdcol_pkg;

    // Per-column drive-level code
    typedef enum logic [1:0] {
        LVL_HI_SEL = 2'b00,
        LVL_HI_UNS = 2'b01,
        LVL_LO_UNS = 2'b10,
        LVL_LO_SEL = 2'b11
    } drive_lvl_e;

    // Line configuration, held constant across one line
    typedef struct packed {
        logic bus8;  // 1: full bus word, 0: low half only
        logic rev;   // 1: fill from the last column downward
    } fill_cfg_t;

    function automatic drive_lvl_e pick_lvl(input logic blank_n,
                                            input logic alt,
                                            input logic dbit);
        drive_lvl_e r;
        if (!blank_n)
            r = LVL_LO_SEL;
        else if (alt)
            r = dbit ? LVL_HI_SEL : LVL_HI_UNS;
        else
            r = dbit ? LVL_LO_SEL : LVL_LO_UNS;
        return r;
    endfunction

endpackage

// File: rtl/lcdcol_fall_det.sv
module lcdcol_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    assign fall = sig_q & ~sig;
endmodule

// File: rtl/lcdcol_capture.sv
module lcdcol_capture
    import lcdcol_pkg::*;
#(
    parameter int NCOL = 160,
    parameter int BUSW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic            clear,
    input  logic            en_n,
    input  fill_cfg_t       cfg,
    input  logic [BUSW-1:0] din,
    output logic [NCOL-1:0] line_q,
    output logic            full_q
);
    localparam int PW = $clog2(NCOL + 1);
    localparam int IW = $clog2(BUSW);

    logic [PW-1:0]   ptr_q;
    logic [PW-1:0]   ptr_nxt;
    logic [IW:0]     wid;
    logic            take;
    logic [NCOL-1:0] hit;
    logic [NCOL-1:0] wbit;

    assign wid     = cfg.bus8 ? (IW+1)'(BUSW) : (IW+1)'(BUSW/2);
    assign take    = step & ~en_n & ~full_q & ~clear;
    assign ptr_nxt = ptr_q + PW'(wid);

    // Per-column write decode: does this word land here, and which bus bit
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic h;
        logic b;
        always_comb begin : decode
            int pos;
            int rel;
            int idx;
            pos = cfg.rev ? (NCOL - 1 - c) : c;
            rel = pos - int'(ptr_q);
            idx = int'(wid) - 1 - rel;
            h   = (rel >= 0) && (rel < int'(wid));
            b   = h ? din[idx[IW-1:0]] : 1'b0;
        end
        assign hit[c]  = h;
        assign wbit[c] = b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            full_q <= 1'b0;
            line_q <= '0;
        end else if (clear) begin
            ptr_q  <= '0;
            full_q <= 1'b0;
        end else if (take) begin
            line_q <= (line_q & ~hit) | wbit;
            ptr_q  <= ptr_nxt;
            full_q <= (ptr_nxt >= PW'(NCOL));
        end
    end

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        full_q && !clear |=> full_q && $stable(line_q) && $stable(ptr_q));
    // R6
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        en_n && !clear |=> $stable(line_q) && $stable(ptr_q));
    // R9
    rewind_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ptr_q == '0) && !full_q);
    // R7
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_q) <= NCOL);
endmodule

// File: rtl/lcdcol_outstage.sv
module lcdcol_outstage
    import lcdcol_pkg::*;
#(
    parameter int NCOL = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer,
    input  logic [NCOL-1:0]   line_in,
    input  logic              alt,
    input  logic              blank_n,
    output logic [2*NCOL-1:0] lvl_o
);
    logic [NCOL-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst)       latch_q <= '0;
        else if (xfer) latch_q <= line_in;
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_lvl
        drive_lvl_e l;
        assign l = pick_lvl(blank_n, alt, latch_q[c]);
        assign lvl_o[2*c +: 2] = l;
    end

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(latch_q));
    // R9
    latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> latch_q == $past(line_in));
endmodule

// File: rtl/lcdcol_driver.sv
module lcdcol_driver
    import lcdcol_pkg::*;
#(
    parameter int NCOL = 160,
    parameter int BUSW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cp_in,
    input  logic              ld_in,
    input  logic              rev,
    input  logic              bus8,
    input  logic [BUSW-1:0]   din,
    input  logic              alt_in,
    input  logic              blank_n,
    input  logic              chain_a_i,
    input  logic              chain_b_i,
    output logic              chain_a_o,
    output logic              chain_b_o,
    output logic [2*NCOL-1:0] col_lvl
);
    fill_cfg_t       cfg;
    logic            cp_fall;
    logic            ld_fall;
    logic            en_n;
    logic            full;
    logic            en_out_n;
    logic [NCOL-1:0] line;

    assign cfg.bus8 = bus8;
    assign cfg.rev  = rev;

    lcdcol_fall_det u_cp_edge (.clk(clk), .rst(rst), .sig(cp_in), .fall(cp_fall));
    lcdcol_fall_det u_ld_edge (.clk(clk), .rst(rst), .sig(ld_in), .fall(ld_fall));

    // Chain pin roles follow the fill direction
    assign en_n      = rev ? chain_b_i : chain_a_i;
    assign en_out_n  = ~full;
    assign chain_a_o = rev ? en_out_n : 1'b1;
    assign chain_b_o = rev ? 1'b1 : en_out_n;

    lcdcol_capture #(.NCOL(NCOL), .BUSW(BUSW)) u_cap (
        .clk(clk), .rst(rst), .step(cp_fall), .clear(ld_fall), .en_n(en_n),
        .cfg(cfg), .din(din), .line_q(line), .full_q(full)
    );

    lcdcol_outstage #(.NCOL(NCOL)) u_out (
        .clk(clk), .rst(rst), .xfer(ld_fall), .line_in(line),
        .alt(alt_in), .blank_n(blank_n), .lvl_o(col_lvl)
    );

    // R5
    idle_pin_chk: assert property (@(posedge clk) disable iff (rst)
        rev ? chain_b_o : chain_a_o);
endmodule

// File: tb/lcdcol_driver_bench.sv
module lcdcol_driver_bench;
    localparam int NCOL = 160;
    localparam int BUSW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cp_in = 1'b0, ld_in = 1'b0, rev = 1'b0, bus8 = 1'b1;
    logic [BUSW-1:0] din = '0;
    logic alt_in = 1'b1, blank_n = 1'b1;
    logic chain_a_i = 1'b0, chain_b_i = 1'b0;
    logic chain_a_o, chain_b_o;
    logic [2*NCOL-1:0] col_lvl;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [NCOL-1:0] m_line = '0;
    logic [NCOL-1:0] m_lat  = '0;
    int m_ptr = 0;
    bit m_full = 0;

    always #5 clk = ~clk;

    lcdcol_driver #(.NCOL(NCOL), .BUSW(BUSW)) u_lcdcol_driver (
        .clk(clk), .rst(rst), .cp_in(cp_in), .ld_in(ld_in), .rev(rev),
        .bus8(bus8), .din(din), .alt_in(alt_in), .blank_n(blank_n),
        .chain_a_i(chain_a_i), .chain_b_i(chain_b_i),
        .chain_a_o(chain_a_o), .chain_b_o(chain_b_o), .col_lvl(col_lvl)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [1:0] exp_code(input logic b);
        if (!blank_n) return 2'b11;
        if (alt_in)   return b ? 2'b00 : 2'b01;
        return b ? 2'b11 : 2'b10;
    endfunction

    task automatic check_cols(input string req);
        int bad_col;
        logic [1:0] g, e;
        bad_col = -1;
        g = 2'b00;
        e = 2'b00;
        for (int c = 0; c < NCOL; c++) begin
            if (bad_col < 0 && col_lvl[2*c +: 2] !== exp_code(m_lat[c])) begin
                bad_col = c;
                g = col_lvl[2*c +: 2];
                e = exp_code(m_lat[c]);
            end
        end
        n_chk++;
        if (bad_col >= 0) begin
            n_bad++;
            $display("FAIL %s: column %0d code %b, expected %b", req, bad_col + 1, g, e);
        end
    endtask

    task automatic check_chain(input string req, input logic ea, input logic eb);
        n_chk++;
        if (chain_a_o !== ea || chain_b_o !== eb) begin
            n_bad++;
            $display("FAIL %s: chain a/b = %b%b, expected %b%b", req,
                     chain_a_o, chain_b_o, ea, eb);
        end
    endtask

    // One strobe; the model applies the fill rules of R2, R3, R4, R6, R7
    task automatic strobe(input logic [7:0] d);
        int w;
        logic en;
        cp_in = 1'b1;
        tick();
        cp_in = 1'b0;
        din = d;
        tick();
        w  = bus8 ? 8 : 4;
        en = rev ? chain_b_i : chain_a_i;
        if (!en && !m_full) begin
            for (int k = 0; k < w; k++) begin
                int col;
                col = rev ? (NCOL - 1 - (m_ptr + k)) : (m_ptr + k);
                m_line[col] = d[w - 1 - k];
            end
            m_ptr += w;
            m_full = (m_ptr >= NCOL);
        end
    endtask

    task automatic xfer();
        ld_in = 1'b1;
        tick();
        ld_in = 1'b0;
        tick();
        m_lat  = m_line;
        m_ptr  = 0;
        m_full = 0;
    endtask

    task automatic sweep_levels(input string req);
        for (int s = 0; s < 4; s++) begin
            alt_in  = s[0];
            blank_n = s[1];
            #1;
            check_cols(req);
        end
        alt_in  = 1'b1;
        blank_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: cleared latch, both chain outputs high
        check_cols("R1");
        check_chain("R1", 1'b1, 1'b1);

        for (int cfg = 0; cfg < 4; cfg++) begin
            string rq;
            int w, n;
            bus8 = cfg[0];
            rev  = cfg[1];
            rq   = rev ? "R4" : (bus8 ? "R2" : "R3");
            chain_a_i = rev ? 1'b1 : 1'b0;   // R5: unused input held inactive
            chain_b_i = rev ? 1'b0 : 1'b1;
            w = bus8 ? 8 : 4;
            n = NCOL / w;
            for (int i = 0; i < n; i++) begin
                logic [7:0] d;
                d = 8'((i * 29 + cfg * 53 + 7) ^ (i << 3));
                if (!bus8) d[7:4] = 4'(i + 5);   // R3: upper half ignored
                strobe(d);
                if (i == n - 2) check_chain("R5", 1'b1, 1'b1);
            end
            // R7 / R5: active output low, idle output high
            check_chain("R7", rev ? 1'b0 : 1'b1, rev ? 1'b1 : 1'b0);
            for (int j = 0; j < 3; j++) strobe(8'hA5 ^ 8'(j));   // R7: ignored
            // R8: nothing visible before the transfer
            check_cols("R8");
            xfer();
            check_chain("R9", 1'b1, 1'b1);
            sweep_levels(rq);
            check_cols("R10");
            blank_n = 1'b0;
            #1;
            check_cols("R11");
            blank_n = 1'b1;
        end

        // R6: chain input high, strobes ignored
        rev = 1'b0;
        bus8 = 1'b1;
        chain_a_i = 1'b1;
        chain_b_i = 1'b0;
        for (int i = 0; i < NCOL / 8; i++) strobe(8'h00);
        check_chain("R6", 1'b1, 1'b1);
        xfer();
        check_cols("R6");

        // R9: a partial line then a transfer; next line restarts at column 1
        chain_a_i = 1'b0;
        strobe(8'h3C);
        strobe(8'hC3);
        xfer();
        check_cols("R9");
        strobe(8'hF0);
        xfer();
        check_cols("R9");
        sweep_levels("R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule